// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers requests from a parameterized number of external interrupt lines, up to 240, and presents a single request to a small processor core. Each line has a sticky pending flag, an enable bit and an 8-bit priority byte. A programmable grouping value splits every priority byte into an upper preemption field and a lower subpriority field. The controller picks the most urgent pending, enabled line that is not already being serviced. It raises a request only when that line's preemption field beats the level of the handler now running. Along with the request it gives the line number and the address of the table word to fetch.

The core acknowledges a request to enter its handler and signals a return when the handler finishes. On acknowledge the controller marks the line active and saves the previous active level and line on a small internal stack. On return it restores them. Acknowledge leaves the pending flag alone, so a line that software never clears is taken again once its handler returns. Software configures everything through a word-addressed register port with combinational read data. Enables and pending flags use separate write-one-to-set and write-one-to-clear addresses.

Top module: `nvpic_top`

## Requirements
- R1: A line that is high during a clock cycle sets its pending flag at the next edge. Writing 1 to a bit at address 0x10+b sets pending flag 32*b+bit. Writing 1 at address 0x18+b clears it. Both addresses read back the pending flags. A flag stays set until it is cleared this way.
- R2: After reset, all enables, pending flags, priorities, the grouping value and the table base are zero, and irq_req is low.
- R3: Writing 1 to a bit at address 0x00+b enables line 32*b+bit, and writing 1 at address 0x08+b disables it. Zero bits have no effect. Both addresses read back the enable bits.
- R4: The grouping value g sits in bits [2:0] of address 0x20. The preemption field is the priority byte shifted right by g, and the low g bits are the subpriority. Nesting compares only the preemption field.
- R5: Among lines that are pending, enabled and not active, the winner has the smallest priority byte, which orders by preemption field and then by subpriority. On an equal byte, the lowest line number wins.
- R6: irq_req is high only when the winner's preemption field is strictly smaller than the active level. With no handler active, the level is 256, below every line.
- R7: irq_ack while irq_req is high and exc_ret is low makes the winner active and pushes the previous level and line. Pending flags are not changed, and an active line is not eligible to win. At most NEST_DEPTH handlers nest.
- R8: exc_ret with a handler active releases the current line and restores the pushed level and line. A released line that is still pending is offered again.
- R9: The table base at address 0x21 reads back with bits [7:0] forced to zero. vec_addr equals the base plus 4*(16+irq_num).
- R10: The priority of line 4*w+k is byte k (bits 8k+7:8k) of address 0x40+w, and it reads back there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_IRQ | External request lines, level sampled |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_ack | input | 1 | Core takes the offered request |
| exc_ret | input | 1 | Core leaves the current handler |
| irq_req | output | 1 | A request may preempt now |
| irq_num | output | 8 | Line number of the winner |
| vec_addr | output | 32 | Table word address for the winner |

## Verification
Every stored value changes at the clock edge that samples a write, a line level, an acknowledge or a return. irq_req, irq_num and vec_addr are combinational from that state, so each result is due one cycle after its stimulus. Register reads carry no latency and are valid in the same cycle that the address is presented. The bench drives inputs on the falling edge and stamps each expected item with the count of the next rising edge. The monitor compares the item one nanosecond after that edge, so every comparison samples settled outputs.

// File: rtl/nvpic_pkg.sv
package nvpic_pkg;

  localparam logic [8:0] IDLE_LVL = 9'd256;

  localparam logic [7:0] A_SETEN   = 8'h00;
  localparam logic [7:0] A_CLREN   = 8'h08;
  localparam logic [7:0] A_SETPEND = 8'h10;
  localparam logic [7:0] A_CLRPEND = 8'h18;
  localparam logic [7:0] A_GROUP   = 8'h20;
  localparam logic [7:0] A_BASE    = 8'h21;
  localparam logic [7:0] A_PRIO    = 8'h40;

  typedef struct packed {
    logic       vld;
    logic [7:0] prio;
    logic [7:0] idx;
  } cand_t;

  // preemption field: priority byte with the g subpriority bits dropped
  function automatic logic [8:0] pre_of(input logic [7:0] prio, input logic [2:0] grp);
    return {1'b0, prio} >> grp;
  endfunction

  // table word of an external line: system entries occupy the first 16 words
  function automatic logic [31:0] vec_of(input logic [31:0] base, input logic [7:0] num);
    return base + (({24'd0, num} + 32'd16) << 2);
  endfunction

  // left operand covers lower line numbers, so it wins on an equal byte
  function automatic cand_t pick(input cand_t l, input cand_t r);
    if (l.vld && (!r.vld || l.prio <= r.prio)) return l;
    return r;
  endfunction

endpackage

// File: rtl/nvpic_regs.sv
module nvpic_regs
  import nvpic_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_IRQ-1:0]     irq_lines,
  input  logic                   reg_we,
  input  logic [7:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  output logic [NUM_IRQ-1:0]     pend_q,
  output logic [NUM_IRQ-1:0]     en_q,
  output logic [NUM_IRQ-1:0][7:0] prio_q,
  output logic [2:0]             grp_q,
  output logic [31:0]            base_q
);

  logic [NUM_IRQ-1:0] set_en, clr_en, set_pend, clr_pend;

  always_comb begin
    for (int i = 0; i < NUM_IRQ; i++) begin
      set_en[i]   = reg_we && reg_addr == 8'(A_SETEN   + i/32) && reg_wdata[i%32];
      clr_en[i]   = reg_we && reg_addr == 8'(A_CLREN   + i/32) && reg_wdata[i%32];
      set_pend[i] = reg_we && reg_addr == 8'(A_SETPEND + i/32) && reg_wdata[i%32];
      clr_pend[i] = reg_we && reg_addr == 8'(A_CLRPEND + i/32) && reg_wdata[i%32];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      prio_q <= '0;
      grp_q  <= '0;
      base_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_pend) | set_pend | irq_lines;
      en_q   <= (en_q & ~clr_en) | set_en;
      if (reg_we && reg_addr == A_GROUP) grp_q <= reg_wdata[2:0];
      if (reg_we && reg_addr == A_BASE)  base_q <= {reg_wdata[31:8], 8'h00};
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (reg_we && reg_addr == 8'(A_PRIO + i/4))
          prio_q[i] <= reg_wdata[8*(i%4) +: 8];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_GROUP) reg_rdata = {29'd0, grp_q};
    if (reg_addr == A_BASE)  reg_rdata = base_q;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (reg_addr == 8'(A_SETEN + i/32) || reg_addr == 8'(A_CLREN + i/32))
        reg_rdata[i%32] = en_q[i];
      if (reg_addr == 8'(A_SETPEND + i/32) || reg_addr == 8'(A_CLRPEND + i/32))
        reg_rdata[i%32] = pend_q[i];
      if (reg_addr == 8'(A_PRIO + i/4))
        reg_rdata[8*(i%4) +: 8] = prio_q[i];
    end
  end

endmodule

// File: rtl/nvpic_arb.sv
module nvpic_arb
  import nvpic_pkg::*;
#(
  parameter int NUM_IRQ = 32
) (
  input  logic [NUM_IRQ-1:0]      elig,
  input  logic [NUM_IRQ-1:0][7:0] prio,
  output cand_t                   win
);

  localparam int LVLS   = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int LEAVES = 1 << LVLS;

  cand_t node [1:2*LEAVES-1];

  genvar k;
  generate
    for (k = 0; k < LEAVES; k++) begin : g_leaf
      if (k < NUM_IRQ) begin : g_real
        assign node[LEAVES+k] = '{vld: elig[k], prio: prio[k], idx: 8'(k)};
      end else begin : g_pad
        assign node[LEAVES+k] = '0;
      end
    end
    for (k = 1; k < LEAVES; k++) begin : g_node
      assign node[k] = pick(node[2*k], node[2*k+1]);
    end
  endgenerate

  assign win = node[1];

endmodule

// File: rtl/nvpic_nest.sv
module nvpic_nest
  import nvpic_pkg::*;
#(
  parameter int NUM_IRQ    = 32,
  parameter int NEST_DEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        take,
  input  logic                        ret,
  input  logic [7:0]                  win_idx,
  input  logic [8:0]                  win_pre,
  output logic [8:0]                  act_lvl,
  output logic [NUM_IRQ-1:0]          act_bits,
  output logic [$clog2(NEST_DEPTH+1)-1:0] depth,
  output logic                        full
);

  localparam int DW = $clog2(NEST_DEPTH + 1);

  logic [8:0] lvl_stk [NEST_DEPTH];
  logic [7:0] idx_stk [NEST_DEPTH];
  logic [7:0] cur_idx;
  logic [8:0] top_lvl;
  logic [7:0] top_idx;

  assign full = (depth == DW'(NEST_DEPTH));

  always_comb begin
    top_lvl = IDLE_LVL;
    top_idx = '0;
    for (int s = 0; s < NEST_DEPTH; s++) begin
      if (depth == DW'(s + 1)) begin
        top_lvl = lvl_stk[s];
        top_idx = idx_stk[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_lvl  <= IDLE_LVL;
      cur_idx  <= '0;
      act_bits <= '0;
      depth    <= '0;
      for (int s = 0; s < NEST_DEPTH; s++) begin
        lvl_stk[s] <= IDLE_LVL;
        idx_stk[s] <= '0;
      end
    end else if (ret && depth != '0) begin
      for (int i = 0; i < NUM_IRQ; i++)
        if (cur_idx == 8'(i)) act_bits[i] <= 1'b0;
      act_lvl <= top_lvl;
      cur_idx <= top_idx;
      depth   <= depth - 1'b1;
    end else if (take && !full) begin
      for (int s = 0; s < NEST_DEPTH; s++) begin
        if (depth == DW'(s)) begin
          lvl_stk[s] <= act_lvl;
          idx_stk[s] <= cur_idx;
        end
      end
      for (int i = 0; i < NUM_IRQ; i++)
        if (win_idx == 8'(i)) act_bits[i] <= 1'b1;
      act_lvl <= win_pre;
      cur_idx <= win_idx;
      depth   <= depth + 1'b1;
    end
  end

endmodule

// File: rtl/nvpic_top.sv
module nvpic_top
  import nvpic_pkg::*;
#(
  parameter int NUM_IRQ    = 32,
  parameter int NEST_DEPTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lines,
  input  logic               reg_we,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               irq_ack,
  input  logic               exc_ret,
  output logic               irq_req,
  output logic [7:0]         irq_num,
  output logic [31:0]        vec_addr
);

  localparam int DW = $clog2(NEST_DEPTH + 1);

  logic [NUM_IRQ-1:0]      pend_q, en_q, act_bits, elig;
  logic [NUM_IRQ-1:0][7:0] prio_q;
  logic [2:0]              grp_q;
  logic [31:0]             base_q;
  cand_t                   win;
  logic [8:0]              win_pre, act_lvl;
  logic [DW-1:0]           depth;
  logic                    full;
  logic                    take_ev, ret_ev;

  nvpic_regs #(.NUM_IRQ(NUM_IRQ)) u_regs (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pend_q(pend_q), .en_q(en_q),
    .prio_q(prio_q), .grp_q(grp_q), .base_q(base_q)
  );

  assign elig = pend_q & en_q & ~act_bits;

  nvpic_arb #(.NUM_IRQ(NUM_IRQ)) u_arb (
    .elig(elig), .prio(prio_q), .win(win)
  );

  assign win_pre = pre_of(win.prio, grp_q);
  assign irq_req = win.vld && (win_pre < act_lvl) && !full;
  assign take_ev = irq_ack && irq_req && !exc_ret;
  assign ret_ev  = exc_ret && (depth != '0);
  assign irq_num = win.idx;
  assign vec_addr = vec_of(base_q, win.idx);

  nvpic_nest #(.NUM_IRQ(NUM_IRQ), .NEST_DEPTH(NEST_DEPTH)) u_nest (
    .clk(clk), .rst_n(rst_n), .take(take_ev), .ret(exc_ret),
    .win_idx(win.idx), .win_pre(win_pre), .act_lvl(act_lvl),
    .act_bits(act_bits), .depth(depth), .full(full)
  );

endmodule

// File: rtl/nvpic_chk.sv
module nvpic_chk #(
  parameter int NUM_IRQ    = 32,
  parameter int NEST_DEPTH = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic                               irq_req,
  input logic [7:0]                         irq_num,
  input logic [8:0]                         act_lvl,
  input logic [8:0]                         win_pre,
  input logic [$clog2(NEST_DEPTH+1)-1:0]    depth,
  input logic                               take_ev,
  input logic                               ret_ev,
  input logic [NUM_IRQ-1:0]                 en_bits,
  input logic [NUM_IRQ-1:0]                 pend_bits
);

  localparam int DW = $clog2(NEST_DEPTH + 1);

  logic sel_en, sel_pend;
  always_comb begin
    sel_en = 1'b0;
    sel_pend = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (irq_num == 8'(i)) begin
        sel_en = en_bits[i];
        sel_pend = pend_bits[i];
      end
    end
  end

  a_r1_req_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> sel_pend);

  a_r3_req_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> sel_en);

  a_r6_strict_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (win_pre < act_lvl));

  a_r7_take_raises: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> (act_lvl < $past(act_lvl)));

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(NEST_DEPTH));

  a_r8_pop_depth: assert property (@(posedge clk) disable iff (!rst_n)
    ret_ev |=> (depth == $past(depth) - 1'b1));

endmodule

bind nvpic_top nvpic_chk #(.NUM_IRQ(NUM_IRQ), .NEST_DEPTH(NEST_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_num(irq_num),
  .act_lvl(act_lvl), .win_pre(win_pre), .depth(depth),
  .take_ev(take_ev), .ret_ev(ret_ev), .en_bits(en_q), .pend_bits(pend_q)
);

// File: tb/sim_nvpic_top.sv
`timescale 1ns/1ps
module sim_nvpic_top;

  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_lines = '0;
  logic          reg_we = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_ack = 1'b0;
  logic          exc_ret = 1'b0;
  logic          irq_req;
  logic [7:0]    irq_num;
  logic [31:0]   vec_addr;

  always #2.5 clk = ~clk;

  nvpic_top #(.NUM_IRQ(N), .NEST_DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ack(irq_ack), .exc_ret(exc_ret),
    .irq_req(irq_req), .irq_num(irq_num), .vec_addr(vec_addr)
  );

  typedef struct {
    int          due;
    bit          is_rd;
    logic [31:0] exp;
    bit          exp_req;
    int          exp_num;
    string       tag;
  } item_t;

  item_t       q[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;
  logic [31:0] base_m = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares every item stamped for this rising edge
  always @(posedge clk) begin
    #1;
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (it.is_rd) begin
        if (reg_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: rdata actual %h expected %h", it.tag, reg_rdata, it.exp);
        end
      end else if (it.exp_req) begin
        if (irq_req !== 1'b1 || irq_num !== 8'(it.exp_num) || vec_addr !== it.exp) begin
          n_bad++;
          $display("FAIL %s: req/num/vec actual %b/%0d/%h expected 1/%0d/%h",
                   it.tag, irq_req, irq_num, vec_addr, it.exp_num, it.exp);
        end
      end else if (irq_req !== 1'b0) begin
        n_bad++;
        $display("FAIL %s: req actual %b expected 0 (num %0d)", it.tag, irq_req, irq_num);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic pulse_line(input int n);
    irq_lines[n] = 1'b1;
    tick();
    irq_lines[n] = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
  endtask

  task automatic ret();
    exc_ret = 1'b1; tick(); exc_ret = 1'b0;
  endtask

  task automatic chk_out(input bit req, input int num, input string tag);
    item_t it;
    it.due = cyc + 1; it.is_rd = 1'b0; it.exp_req = req; it.exp_num = num;
    it.exp = base_m + 32'((num + 16) * 4); it.tag = tag;
    q.push_back(it);
    tick();
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    reg_addr = a;
    it.due = cyc + 1; it.is_rd = 1'b1; it.exp = e; it.exp_req = 1'b0;
    it.exp_num = 0; it.tag = tag;
    q.push_back(it);
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    // R2 reset state
    chk_out(0, 0, "R2 no request after reset");
    chk_rd(8'h00, 32'h0, "R2 enables clear");
    chk_rd(8'h10, 32'h0, "R2 pending clear");
    chk_rd(8'h20, 32'h0, "R2 grouping zero");
    chk_rd(8'h21, 32'h0, "R2 base zero");
    // R1 line latches pending, R2 disabled line not offered
    pulse_line(3);
    chk_rd(8'h10, 32'h8, "R1 line 3 pending");
    chk_out(0, 0, "R2 disabled line not served");
    // R3 set-enable
    wr(8'h00, 32'h8);
    chk_out(1, 3, "R3 enabled line 3 offered");
    // R9 base relocation
    wr(8'h21, 32'h1234_5678);
    base_m = 32'h1234_5600;
    chk_rd(8'h21, 32'h1234_5600, "R9 base low byte forced zero");
    chk_out(1, 3, "R9 vector from relocated base");
    // R3 zero writes ignored
    wr(8'h00, 32'h0);
    chk_rd(8'h00, 32'h8, "R3 zero set-enable no effect");
    wr(8'h08, 32'h0);
    chk_rd(8'h08, 32'h8, "R3 zero clear-enable no effect");
    wr(8'h08, 32'h8);
    chk_out(0, 0, "R3 clear-enable stops request");
    chk_rd(8'h00, 32'h0, "R3 enable reads zero");
    // R4 grouping 5, R10 priorities
    wr(8'h20, 32'd5);
    chk_rd(8'h20, 32'd5, "R4 grouping readback");
    wr(8'h40, 32'h8000_0000);
    wr(8'h41, 32'h7F00_6000);
    wr(8'h42, 32'h0000_2000);
    chk_rd(8'h41, 32'h7F00_6000, "R10 priority word readback");
    wr(8'h10, 32'hA0);
    chk_rd(8'h10, 32'hA8, "R1 set-pending");
    wr(8'h00, 32'hA8);
    chk_out(1, 5, "R5 subpriority picks line 5");
    ack();
    chk_rd(8'h10, 32'hA8, "R7 ack keeps pending");
    chk_out(0, 0, "R6 equal preemption cannot nest");
    pulse_line(9);
    wr(8'h00, 32'h200);
    chk_out(1, 9, "R6 higher preemption offered");
    ack();
    chk_out(0, 0, "R7 active line excluded");
    ret();
    chk_out(1, 9, "R8 pending line taken again after return");
    wr(8'h18, 32'h200);
    chk_out(0, 0, "R1 clear-pending removes line 9");
    chk_rd(8'h10, 32'hA8, "R1 pending after clear");
    ret();
    chk_out(1, 5, "R8 idle after return, line 5 again");
    // R5 tie on equal byte: lowest line
    wr(8'h41, 32'h6000_6000);
    chk_out(1, 5, "R5 tie lowest index");
    wr(8'h41, 32'h5F00_6000);
    chk_out(1, 7, "R5 smaller byte wins");
    wr(8'h41, 32'h7F00_6000);
    // R4 grouping 7: 0x20 and 0x60 share preemption 0
    wr(8'h20, 32'd7);
    chk_out(1, 5, "R4 winner under grouping 7");
    ack();
    pulse_line(9);
    chk_out(0, 0, "R4 grouping 7 blocks nesting");
    ret();
    chk_out(1, 9, "R4 line 9 wins when idle");
    wr(8'h20, 32'd5);
    wr(8'h08, 32'h200);
    chk_out(1, 5, "R4 line 5 with line 9 disabled");
    ack();
    wr(8'h00, 32'h200);
    chk_out(1, 9, "R4 grouping 5 lets line 9 nest");
    repeat (2) tick();
    if (q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL scoreboard: items left actual %0d expected 0", q.size());
    end
    finish_run();
  end

endmodule